// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the source and destination addresses for a single DMA channel. Software first programs an 8-bit address-control byte and two 16-bit starting addresses through a byte-wide write port. It then sets the transfer geometry (burst length, block length, number of blocks) and pulses `start`. From then on, every `byte_done` strobe marks one moved byte. On each strobe the source and destination addresses are stepped in their own direction, which is held, counted up or counted down.

Each side also has its own reload point. At the chosen boundary (end of a burst, end of a block or end of the whole transaction) the address returns to the starting value that software wrote. The channel stays busy until the last byte of the last block. At that point it drops `busy` and pulses `xfer_done` for one cycle. The control byte is frozen while the channel is busy, so the mode cannot change in the middle of a transaction.

Top module: `dma_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, the control byte, both starting addresses and both current addresses are zero, and `busy` and `xfer_done` are low.
- R2: A write with `wr_ofs` = 2 loads the control byte with this layout: bits 7:6 source reload, bits 5:4 source direction, bits 3:2 destination reload, bits 1:0 destination direction. Offsets 4 and 5 hold the source starting address (low byte, then high byte). Offsets 6 and 7 hold the destination starting address in the same way.
- R3: A `start` pulse while idle copies both starting addresses into the current addresses and raises `busy` on the next cycle. A `start` pulse while busy is ignored.
- R4: On each `byte_done` while busy, an address with direction 01 goes up by one and an address with direction 10 goes down by one. Addresses wrap modulo 2^16. Direction 00 and the reserved value 11 leave the address unchanged.
- R5: The reload field selects where the address returns to its starting value: 00 never, 01 at each block end, 10 at each burst end, 11 at the transaction end. When a reload and a step fall on the same byte, the reload wins.
- R6: `burst_sel` values 00, 01, 10 and 11 give bursts of 1, 2, 4 and 8 bytes. A burst is also cut short at each block end, and the next burst starts with the next block.
- R7: `block_len` gives the bytes per block and `repeat_cnt` gives the blocks per transaction. A zero in either counts as one. Both are captured at `start`.
- R8: On the final byte of the transaction, `busy` falls and `xfer_done` is high for exactly one cycle. At that byte, every reload point that has been reached (burst, block and transaction) is applied.
- R9: A write to the control byte while `busy` is high has no effect on the addresses of the running transaction or of later ones.
- R10: Source and destination apply their own reload and direction fields independently of each other.
- R11: A `byte_done` strobe while idle changes neither address nor `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ofs | input | 3 | Register offset within the channel |
| wr_data | input | 8 | Register write data |
| start | input | 1 | Begin a transaction |
| byte_done | input | 1 | One byte has been moved |
| burst_sel | input | 2 | Burst length code |
| block_len | input | 16 | Bytes per block |
| repeat_cnt | input | 8 | Blocks per transaction |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |
| busy | output | 1 | Transaction in progress |
| xfer_done | output | 1 | One-cycle pulse at transaction end |

## Verification
The embedded assertions check several rules on every cycle:
- the control byte is frozen while busy;
- an address holds whenever there is neither a start nor a byte strobe;
- a start loads the starting addresses;
- `busy` can only fall together with a `xfer_done` pulse, and the two are never high together.

Other behaviour only the bench's scenarios can show, by comparing each address after every byte against a reference model:
- whether each reload point falls on the right byte across many burst, block and repeat shapes;
- that a reload takes priority over a step;
- wrap-around at both ends of the address range;
- that zero-sized geometry is treated as one.

// File: rtl/dma_addr_pkg.sv
// Package: shared encodings and types for the DMA channel address generator.
// Assumes a byte-wide register port with a 3-bit channel-relative offset.
package dma_addr_pkg;

    typedef enum logic [1:0] {
        RLD_NONE  = 2'b00,
        RLD_BLOCK = 2'b01,
        RLD_BURST = 2'b10,
        RLD_TXN   = 2'b11
    } reload_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10,
        DIR_RSVD = 2'b11
    } dir_e;

    typedef struct packed {
        reload_e src_rld;
        dir_e    src_dir;
        reload_e dst_rld;
        dir_e    dst_dir;
    } addr_ctrl_t;

    typedef struct packed {
        logic burst_end;
        logic block_end;
        logic txn_end;
    } bound_t;

    localparam logic [2:0] OFS_CTRL   = 3'h2;
    localparam logic [2:0] OFS_SRC_LO = 3'h4;
    localparam logic [2:0] OFS_SRC_HI = 3'h5;
    localparam logic [2:0] OFS_DST_LO = 3'h6;
    localparam logic [2:0] OFS_DST_HI = 3'h7;

endpackage

// File: rtl/dma_ctrl_regs.sv
// Module: channel register file. Holds the address-control byte and the
// source/destination starting addresses. The control byte ignores writes
// while the channel is busy; starting addresses are always writable.
// Assumes 8 < ADDR_W <= 16 (low byte plus a partial or full high byte).
module dma_ctrl_regs
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_ofs,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output addr_ctrl_t        ctrl,
    output logic [ADDR_W-1:0] src_init,
    output logic [ADDR_W-1:0] dst_init
);
    localparam int HI_W = ADDR_W - 8;

    // Control byte: written only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && !busy && wr_ofs == OFS_CTRL) begin
            ctrl <= addr_ctrl_t'(wr_data);
        end
    end

    // Starting addresses: byte-lane writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_init <= '0;
            dst_init <= '0;
        end else if (wr_en) begin
            case (wr_ofs)
                OFS_SRC_LO: src_init[7:0]        <= wr_data;
                OFS_SRC_HI: src_init[ADDR_W-1:8] <= wr_data[HI_W-1:0];
                OFS_DST_LO: dst_init[7:0]        <= wr_data;
                OFS_DST_HI: dst_init[ADDR_W-1:8] <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // R9: control byte frozen while the channel is busy
    p_ctrl_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl));

endmodule

// File: rtl/dma_xfer_seq.sv
// Module: transfer sequencer. Captures the geometry at start, counts bytes
// within bursts and blocks and counts blocks. It flags the burst, block
// and transaction boundaries on the byte that completes them, and owns
// busy and the done pulse. Zero block length or repeat count acts as one.
module dma_xfer_seq
    import dma_addr_pkg::*;
#(
    parameter int BLK_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             byte_done,
    input  logic [1:0]       burst_sel,
    input  logic [BLK_W-1:0] block_len,
    input  logic [REP_W-1:0] repeat_cnt,
    output logic             busy,
    output logic             done,
    output logic             start_ld,
    output logic             step,
    output bound_t           bnd
);
    logic [1:0]       burst_q;
    logic [BLK_W-1:0] blk_len_q;
    logic [REP_W-1:0] rep_q;
    logic [2:0]       bcnt;
    logic [BLK_W-1:0] kcnt;
    logic [REP_W-1:0] rcnt;

    assign start_ld = start && !busy;
    assign step     = byte_done && busy;

    // Boundary decode for the byte being completed.
    always_comb begin
        bnd.block_end = ({1'b0, kcnt} + 1'b1) >= {1'b0, blk_len_q};
        bnd.txn_end   = bnd.block_end && (({1'b0, rcnt} + 1'b1) >= {1'b0, rep_q});
        bnd.burst_end = bnd.block_end || (({1'b0, bcnt} + 4'd1) == (4'd1 << burst_q));
    end

    // Geometry capture, counters, busy and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            burst_q   <= '0;
            blk_len_q <= '0;
            rep_q     <= '0;
            bcnt      <= '0;
            kcnt      <= '0;
            rcnt      <= '0;
        end else begin
            done <= 1'b0;
            if (start_ld) begin
                busy      <= 1'b1;
                burst_q   <= burst_sel;
                blk_len_q <= block_len;
                rep_q     <= repeat_cnt;
                bcnt      <= '0;
                kcnt      <= '0;
                rcnt      <= '0;
            end else if (step) begin
                bcnt <= bnd.burst_end ? 3'd0 : bcnt + 3'd1;
                kcnt <= bnd.block_end ? '0 : kcnt + 1'b1;
                if (bnd.block_end) rcnt <= rcnt + 1'b1;
                if (bnd.txn_end) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R3: an idle start makes the channel busy
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ld |=> busy);
    // R8: the done pulse never overlaps busy
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: busy only falls together with the done pulse
    p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R8: done lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/dma_addr_lane.sv
// Module: one address lane (source or destination). Loads the starting
// address at start, then steps by the direction field on every byte,
// returning to the starting address when the selected boundary is hit.
// Reload wins over a step; reserved direction 11 holds the address.
module dma_addr_lane
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ld,
    input  logic              step,
    input  logic [1:0]        rld_sel,
    input  logic [1:0]        dir_sel,
    input  bound_t            bnd,
    input  logic [ADDR_W-1:0] init,
    output logic [ADDR_W-1:0] cur
);
    logic              hit;
    logic [ADDR_W-1:0] stepped;

    // Select whether this byte hits the lane's reload point.
    always_comb begin
        case (reload_e'(rld_sel))
            RLD_BLOCK: hit = bnd.block_end;
            RLD_BURST: hit = bnd.burst_end;
            RLD_TXN:   hit = bnd.txn_end;
            default:   hit = 1'b0;
        endcase
    end

    // Compute the stepped address with modular wrap.
    always_comb begin
        case (dir_e'(dir_sel))
            DIR_UP:   stepped = cur + 1'b1;
            DIR_DOWN: stepped = cur - 1'b1;
            default:  stepped = cur;
        endcase
    end

    // Current address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (start_ld) begin
            cur <= init;
        end else if (step) begin
            cur <= hit ? init : stepped;
        end
    end

    // R11: no start and no byte means the address holds
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start_ld && !step |=> $stable(cur));
    // R3: start copies the starting address
    p_load_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ld |=> cur == $past(init));

endmodule

// File: rtl/dma_addr_gen.sv
// Module: DMA channel address generator top. Ties the register file, the
// transfer sequencer and one address lane per side together. Lane 0 is
// the source and lane 1 is the destination. Assumes byte_done only
// arrives for bytes actually moved by the channel.
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 16,
    parameter int REP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_ofs,
    input  logic [7:0]        wr_data,
    input  logic              start,
    input  logic              byte_done,
    input  logic [1:0]        burst_sel,
    input  logic [BLK_W-1:0]  block_len,
    input  logic [REP_W-1:0]  repeat_cnt,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              busy,
    output logic              xfer_done
);
    localparam int N_LANE = 2;

    addr_ctrl_t                      ctrl;
    logic [ADDR_W-1:0]               src_init, dst_init;
    logic                            start_ld, step;
    bound_t                          bnd;
    logic [N_LANE-1:0][1:0]          rld_a, dir_a;
    logic [N_LANE-1:0][ADDR_W-1:0]   init_a, cur_a;

    dma_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs),
        .wr_data(wr_data), .busy(busy), .ctrl(ctrl),
        .src_init(src_init), .dst_init(dst_init)
    );

    dma_xfer_seq #(.BLK_W(BLK_W), .REP_W(REP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_done(byte_done),
        .burst_sel(burst_sel), .block_len(block_len), .repeat_cnt(repeat_cnt),
        .busy(busy), .done(xfer_done), .start_ld(start_ld), .step(step),
        .bnd(bnd)
    );

    // Per-lane field routing.
    always_comb begin
        rld_a[0]  = ctrl.src_rld;
        dir_a[0]  = ctrl.src_dir;
        init_a[0] = src_init;
        rld_a[1]  = ctrl.dst_rld;
        dir_a[1]  = ctrl.dst_dir;
        init_a[1] = dst_init;
    end

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        dma_addr_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .start_ld(start_ld), .step(step),
            .rld_sel(rld_a[g]), .dir_sel(dir_a[g]), .bnd(bnd),
            .init(init_a[g]), .cur(cur_a[g])
        );
    end

    assign src_addr = cur_a[0];
    assign dst_addr = cur_a[1];

endmodule

// File: tb/tb_dma_addr_gen.sv
// Bench: seeded random transactions plus directed corners, each address
// checked after every byte against a reference model built in functions.
module tb_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_ofs = '0;
    logic [7:0]  wr_data = '0;
    logic        start = 1'b0;
    logic        byte_done = 1'b0;
    logic [1:0]  burst_sel = '0;
    logic [15:0] block_len = '0;
    logic [7:0]  repeat_cnt = '0;
    logic [15:0] src_addr, dst_addr;
    logic        busy, xfer_done;

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    logic [7:0]  m_ctrl;
    logic [15:0] m_si, m_di, m_src, m_dst;
    int          m_bl, m_kl, m_rp, m_b, m_k, m_r;
    bit          m_busy, m_last;

    dma_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs),
        .wr_data(wr_data), .start(start), .byte_done(byte_done),
        .burst_sel(burst_sel), .block_len(block_len), .repeat_cnt(repeat_cnt),
        .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy),
        .xfer_done(xfer_done)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] f_step(input logic [15:0] a, input logic [1:0] d);
        case (d)
            2'b01:   return a + 16'd1;
            2'b10:   return a - 16'd1;
            default: return a;
        endcase
    endfunction

    function automatic bit f_hit(input logic [1:0] r, input bit be, input bit ke, input bit te);
        case (r)
            2'b01:   return ke;
            2'b10:   return be;
            2'b11:   return te;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] o, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ofs = o; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [7:0] c, input logic [15:0] si, input logic [15:0] di);
        wr(3'h2, c);
        wr(3'h4, si[7:0]); wr(3'h5, si[15:8]);
        wr(3'h6, di[7:0]); wr(3'h7, di[15:8]);
        m_ctrl = c; m_si = si; m_di = di;
    endtask

    task automatic go(input logic [1:0] bs, input logic [15:0] bl, input logic [7:0] rp);
        burst_sel = bs; block_len = bl; repeat_cnt = rp;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_bl = 1 << bs; m_kl = (bl == 0) ? 1 : int'(bl); m_rp = (rp == 0) ? 1 : int'(rp);
        m_b = 0; m_k = 0; m_r = 0; m_busy = 1'b1;
        m_src = m_si; m_dst = m_di;
        chk(busy == 1'b1, "R3", "busy after start", busy, 1);
        chk(src_addr == m_src, "R3", "src load", src_addr, m_src);
        chk(dst_addr == m_dst, "R3", "dst load", dst_addr, m_dst);
    endtask

    // Model of one byte, per R4..R8 and R10.
    task automatic model_byte();
        bit ke, be, te;
        ke = (m_k + 1 >= m_kl);
        be = ke || (m_b + 1 == m_bl);
        te = ke && (m_r + 1 >= m_rp);
        m_src = f_hit(m_ctrl[7:6], be, ke, te) ? m_si : f_step(m_src, m_ctrl[5:4]);
        m_dst = f_hit(m_ctrl[3:2], be, ke, te) ? m_di : f_step(m_dst, m_ctrl[1:0]);
        m_b = be ? 0 : m_b + 1;
        m_k = ke ? 0 : m_k + 1;
        if (ke) m_r++;
        m_last = te;
        if (te) m_busy = 1'b0;
    endtask

    task automatic one_byte(input string req);
        @(negedge clk);
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
        model_byte();
        chk(src_addr == m_src, req, "src addr", src_addr, m_src);
        chk(dst_addr == m_dst, "R10", "dst addr", dst_addr, m_dst);
        chk(busy == m_busy, "R8", "busy", busy, m_busy);
        chk(xfer_done == m_last, "R8", "done pulse", xfer_done, m_last);
        if (m_last) begin
            @(negedge clk);
            chk(xfer_done == 1'b0, "R8", "done single cycle", xfer_done, 0);
        end
    endtask

    task automatic run_all(input string req, input bit disturb);
        while (m_busy) begin
            if (disturb && ($urandom % 6 == 0)) wr(3'h2, 8'($urandom));   // R9 attempt
            if (disturb && ($urandom % 8 == 0)) begin                      // R3 start while busy
                @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
            end
            repeat ($urandom % 3) @(negedge clk);
            one_byte(req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(src_addr == 16'h0, "R1", "src reset", src_addr, 0);
        chk(dst_addr == 16'h0, "R1", "dst reset", dst_addr, 0);
        chk(busy == 1'b0, "R1", "busy reset", busy, 0);
        chk(xfer_done == 1'b0, "R1", "done reset", xfer_done, 0);

        // R2: layout - src no reload, up; dst no reload, down
        setup(8'b00_01_00_10, 16'h1200, 16'h3400);
        go(2'd3, 16'd5, 8'd1);
        run_all("R2", 1'b0);
        chk(src_addr == 16'h1205, "R2", "src field position", src_addr, 16'h1205);
        chk(dst_addr == 16'h33FB, "R2", "dst field position", dst_addr, 16'h33FB);

        // R11: byte while idle
        one_byte_idle();

        // R4: wrap at both ends, reserved direction holds
        setup(8'b00_01_00_11, 16'hFFFE, 16'h0001);
        go(2'd0, 16'd4, 8'd1);
        run_all("R4", 1'b0);
        chk(src_addr == 16'h0002, "R4", "wrap up", src_addr, 16'h0002);
        chk(dst_addr == 16'h0001, "R4", "reserved holds", dst_addr, 16'h0001);
        setup(8'b00_10_00_00, 16'h0001, 16'h5555);
        go(2'd0, 16'd3, 8'd1);
        run_all("R4", 1'b0);
        chk(src_addr == 16'hFFFE, "R4", "wrap down", src_addr, 16'hFFFE);

        // R7: zero geometry counts as one -> one-byte transaction
        setup(8'b11_01_01_01, 16'h0100, 16'h0200);
        go(2'd2, 16'd0, 8'd0);
        run_all("R7", 1'b0);
        chk(busy == 1'b0, "R7", "single byte ends", busy, 0);

        // R6/R5: burst of 4 cut by block of 6, burst reload on src, block reload on dst
        setup(8'b10_01_01_10, 16'h2000, 16'h4000);
        go(2'd2, 16'd6, 8'd2);
        run_all("R6", 1'b0);
        // R8: transaction reload with other points coinciding on last byte
        setup(8'b11_01_10_01, 16'h0A00, 16'h0B00);
        go(2'd1, 16'd4, 8'd3);
        run_all("R8", 1'b0);
        chk(src_addr == 16'h0A00, "R8", "txn reload at end", src_addr, 16'h0A00);
        chk(dst_addr == 16'h0B00, "R8", "burst reload at end", dst_addr, 16'h0B00);

        // R9: locked control byte during a run, verified in next transaction
        setup(8'b00_01_00_01, 16'h0300, 16'h0400);
        go(2'd0, 16'd3, 8'd1);
        wr(3'h2, 8'b00_10_00_10);
        run_all("R9", 1'b0);
        chk(src_addr == 16'h0303, "R9", "locked write ignored", src_addr, 16'h0303);
        m_si = 16'h0303; m_di = 16'h0403;
        wr(3'h4, 8'h03); wr(3'h6, 8'h03);
        go(2'd0, 16'd2, 8'd1);
        run_all("R9", 1'b0);
        chk(src_addr == 16'h0305, "R9", "mode kept after run", src_addr, 16'h0305);

        // R5/R10: random transactions with disturbances
        for (int t = 0; t < 60; t++) begin
            setup(8'($urandom), 16'($urandom), 16'($urandom));
            go(2'($urandom), 16'($urandom % 13), 8'($urandom % 5));
            run_all("R5", 1'b1);
        end
        one_byte_idle();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    task automatic one_byte_idle();
        logic [15:0] s0, d0;
        s0 = src_addr; d0 = dst_addr;
        @(negedge clk); byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0;
        @(negedge clk);
        chk(src_addr == s0, "R11", "src idle byte", src_addr, s0);
        chk(dst_addr == d0, "R11", "dst idle byte", dst_addr, d0);
        chk(busy == 1'b0, "R11", "busy idle byte", busy, 0);
    endtask

endmodule